// File: doc/BRIEF.md
# Serial Port Direction Bring-up Sequencer

This block owns the global control word of one direction (transmit or receive) of a serial audio port and walks the sub-units of that direction out of reset one at a time. On a start request it releases the high-frequency clock divider first, then the bit clock divider, then the serializer clear. It then issues one dummy write to the data buffer and releases the state machine, followed by the frame sync generator. Each release is confirmed by an acknowledge from the sub-unit before the next one is made, and a bounded poll count turns a missing acknowledge into an error.

In the transmit build, after the frame sync release the sequencer also waits a bounded time for the first transmit serializer to report ready. It then issues a second dummy buffer write. A stop request clears the entire control word in one step and pulses a status-clear strobe. The direction, the acknowledge poll limit and the ready poll limit are parameters.

Top module: `serdir_bringup`

## Requirements
- R1: After reset the control word is zero, and `done`, `err`, `buf_wr` and `stat_clr` are all low.
- R2: Control bit positions within a 5-bit group are: bit 0 bit clock divider, bit 1 high-frequency divider, bit 2 serializer clear, bit 3 state machine, bit 4 frame sync. The group sits at bits 0..4 for receive and at bits 8..12 for transmit, and the other byte stays zero. The bits are set in the order 1, 0, 2, 3, 4, and each stays set until stop or error. The edge that accepts a start sets only bit 1.
- R3: While a step waits, `unit_ack[k]` is sampled on every clock edge, where k is the bit position of the step's sub-unit. The edge that first sees it high moves to the next step, so the next release appears one cycle later.
- R4: If a step samples its acknowledge low on `POLL_LIMIT` consecutive edges, the sequencer clears the whole control word on that edge and raises `err`.
- R5: `buf_wr` is high for exactly one cycle between the serializer clear acknowledge and the state machine release. The transmit build gives a second one-cycle pulse after serializer ready is seen.
- R6: The transmit build samples `ser_ready` after the frame sync acknowledge and errors after `READY_LIMIT` low samples. The receive build finishes directly after the frame sync acknowledge.
- R7: `done` rises only after every step has succeeded, with all five bits of the group set. It stays high until stop.
- R8: A start request is ignored while a sequence is in progress or finished. Start is accepted only from idle or from the error state.
- R9: Stop has priority over start. On the next edge it clears the control word and `done`, and `stat_clr` is high for exactly that one cycle.
- R10: `err` stays high, even through stop, until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Begin the bring-up sequence |
| stop_req | input | 1 | Shut the direction down |
| ser_ready | input | 1 | First transmit serializer ready state |
| unit_ack | input | 5 | Per sub-unit release readback, indexed by control bit position |
| ctl | output | 16 | Global control word (receive group bits 0..4, transmit group bits 8..12) |
| buf_wr | output | 1 | Dummy zero write strobe to the data buffer |
| stat_clr | output | 1 | Write-all-ones strobe to the status register |
| done | output | 1 | All steps completed |
| err | output | 1 | A step or the ready wait timed out |

## Verification
The hardest situations to reach are the exact poll-limit boundaries. The first is an acknowledge that arrives on the last permitted sample rather than one sample too late. The second is a ready flag that was already high, or nearly high, by the time the ready wait begins. The bench models each sub-unit as answering a set number of cycles after its enable rises, and models ready as counting from the frame sync release. Directed latencies of limit-1 and limit on a single step therefore land on each side of the error boundary. Random latencies then cover the ordering and timing elsewhere. A start pulse injected in mid-sequence must leave the completion cycle unchanged.

// File: rtl/serdir_bringup.sv
module serdir_bringup #(
  parameter bit IS_TX       = 1'b1,
  parameter int POLL_LIMIT  = 1000,
  parameter int READY_LIMIT = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        stop_req,
  input  logic        ser_ready,
  input  logic [4:0]  unit_ack,
  output logic [15:0] ctl,
  output logic        buf_wr,
  output logic        stat_clr,
  output logic        done,
  output logic        err
);
  localparam int OFS = IS_TX ? 8 : 0;
  localparam int MAXL = (POLL_LIMIT > READY_LIMIT) ? POLL_LIMIT : READY_LIMIT;
  localparam int CW = $clog2(MAXL + 1);

  typedef enum logic [3:0] {IDLE, W_HF, W_CK, W_SC, WR0, W_SM, W_FS, W_RDY, WR1, FIN, FAIL} st_t;

  st_t           st, nxt;
  logic [4:0]    en, nset;
  logic [CW-1:0] cnt;
  logic          pbit, polling, lim_hit;

  assign ctl    = {11'd0, en} << OFS;
  assign buf_wr = (st == WR0) || (st == WR1);
  assign done   = (st == FIN);

  always_comb begin
    pbit = 1'b0;
    nxt  = st;
    nset = 5'd0;
    case (st)
      W_HF:  begin pbit = unit_ack[1]; nxt = W_CK; nset = 5'b00001; end
      W_CK:  begin pbit = unit_ack[0]; nxt = W_SC; nset = 5'b00100; end
      W_SC:  begin pbit = unit_ack[2]; nxt = WR0; end
      W_SM:  begin pbit = unit_ack[3]; nxt = W_FS; nset = 5'b10000; end
      W_FS:  begin pbit = unit_ack[4]; nxt = IS_TX ? W_RDY : FIN; end
      W_RDY: begin pbit = ser_ready;   nxt = WR1; end
      default: ;
    endcase
  end

  assign polling = (st == W_HF) || (st == W_CK) || (st == W_SC) ||
                   (st == W_SM) || (st == W_FS) || (st == W_RDY);
  assign lim_hit = (st == W_RDY) ? (cnt == CW'(READY_LIMIT - 1))
                                 : (cnt == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      en       <= '0;
      cnt      <= '0;
      err      <= 1'b0;
      stat_clr <= 1'b0;
    end else begin
      stat_clr <= stop_req;
      if (stop_req) begin
        st  <= IDLE;
        en  <= '0;
        cnt <= '0;
      end else if (polling) begin
        if (pbit) begin
          st  <= nxt;
          en  <= en | nset;
          cnt <= '0;
        end else if (lim_hit) begin
          st  <= FAIL;
          en  <= '0;
          cnt <= '0;
          err <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        case (st)
          IDLE, FAIL: if (start_req) begin
            st  <= W_HF;
            en  <= 5'b00010;
            cnt <= '0;
            err <= 1'b0;
          end
          WR0: begin
            st    <= W_SM;
            en[3] <= 1'b1;
          end
          WR1: st <= FIN;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serdir_bringup_chk.sv
module serdir_bringup_chk #(
  parameter bit IS_TX = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stop_req,
  input logic [4:0]  unit_ack,
  input logic [15:0] ctl,
  input logic        buf_wr,
  input logic        stat_clr,
  input logic        done,
  input logic        err
);
  localparam int OFS = IS_TX ? 8 : 0;

  AST_CK_AFTER_HF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[OFS+0]) |-> ctl[OFS+1]); // R2
  AST_CLR_AFTER_CK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[OFS+2]) |-> ctl[OFS+0]); // R2
  AST_CK_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[OFS+0]) |-> $past(unit_ack[1])); // R3
  AST_SM_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[OFS+3]) |-> $past(buf_wr)); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ctl == 16'd0) && !done); // R4
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctl[OFS+:5] == 5'h1f)); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (ctl == 16'd0) && stat_clr && !done); // R9
endmodule

bind serdir_bringup serdir_bringup_chk #(.IS_TX(IS_TX)) u_chk (.*);

// File: tb/sim_serdir_bringup.sv
module sim_serdir_bringup;
  localparam int PL = 16;
  localparam int RL = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [4:0] ack_tx, ack_rx;
  logic rdy;
  logic [15:0] ctl_tx, ctl_rx;
  logic bw_tx, bw_rx, sc_tx, sc_rx, dn_tx, dn_rx, er_tx, er_rx;

  int checks = 0, errors = 0, cycles = 0, viol = 0;
  int lat[5];
  int rl;
  int ctx[5], crx[5], rc;

  always #2 clk = ~clk;

  serdir_bringup #(.IS_TX(1'b1), .POLL_LIMIT(PL), .READY_LIMIT(RL)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start), .stop_req(stop), .ser_ready(rdy),
    .unit_ack(ack_tx), .ctl(ctl_tx), .buf_wr(bw_tx), .stat_clr(sc_tx), .done(dn_tx), .err(er_tx));

  serdir_bringup #(.IS_TX(1'b0), .POLL_LIMIT(PL), .READY_LIMIT(RL)) u1 (
    .clk(clk), .rst_n(rst_n), .start_req(start), .stop_req(stop), .ser_ready(1'b0),
    .unit_ack(ack_rx), .ctl(ctl_rx), .buf_wr(bw_rx), .stat_clr(sc_rx), .done(dn_rx), .err(er_rx));

  always_ff @(posedge clk) begin
    for (int i = 0; i < 5; i++) begin
      ctx[i] <= ctl_tx[8+i] ? ctx[i] + 1 : 0;
      crx[i] <= ctl_rx[i] ? crx[i] + 1 : 0;
    end
    rc <= ctl_tx[12] ? rc + 1 : 0;
  end

  always_comb begin
    for (int i = 0; i < 5; i++) begin
      ack_tx[i] = ctl_tx[8+i] && (ctx[i] >= lat[i]);
      ack_rx[i] = ctl_rx[i] && (crx[i] >= lat[i]);
    end
    rdy = ctl_tx[12] && (rc >= rl);
  end

  logic [4:0] prev_tx = 5'd0, prev_rx = 5'd0;
  function automatic int bad_rise(logic [4:0] p, logic [4:0] n);
    int b = 0;
    if (n[0] && !p[0] && !p[1]) b++;
    if (n[2] && !p[2] && !p[0]) b++;
    if (n[3] && !p[3] && !p[2]) b++;
    if (n[4] && !p[4] && !p[3]) b++;
    return b;
  endfunction
  always @(negedge clk) begin
    cycles++;
    viol += bad_rise(prev_tx, ctl_tx[12:8]) + bad_rise(prev_rx, ctl_rx[4:0]);
    prev_tx = ctl_tx[12:8];
    prev_rx = ctl_rx[4:0];
    if (ctl_tx[7:0] != 8'd0 || ctl_tx[15:13] != 3'd0 || ctl_rx[15:5] != 11'd0) viol++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int exp_time(bit tx, output bit e, output int nb);
    int ord[5] = '{1, 0, 2, 3, 4};
    int t = 0;
    int p;
    e = 1'b0;
    nb = 0;
    for (int i = 0; i < 5; i++) begin
      if (lat[ord[i]] >= PL) begin e = 1'b1; return t + PL; end
      t += lat[ord[i]] + 1;
      if (i == 2) begin t += 1; nb = 1; end
    end
    if (!tx) return t;
    p = rl - lat[4] - 1;
    if (p < 0) p = 0;
    if (p >= RL) begin e = 1'b1; return t + RL; end
    nb = 2;
    return t + p + 2;
  endfunction

  task automatic setlat(int a, int b, int c, int d, int f, int r);
    lat[0] = a; lat[1] = b; lat[2] = c; lat[3] = d; lat[4] = f; rl = r;
  endtask

  task automatic run(bit mid);
    int c = 0, ttx = -1, trx = -1, nbt = 0, nbr = 0, xt, xr, nbxt, nbxr;
    bit etx = 0, erx = 0, xet, xer;
    string rq;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ctl_tx == 16'h0200, "R2", ctl_tx, 16'h0200);
    chk(ctl_rx == 16'h0002, "R2", ctl_rx, 16'h0002);
    chk(!er_tx && !er_rx, "R10", er_tx + er_rx, 0);
    while ((ttx < 0 || trx < 0) && c < 3000) begin
      @(negedge clk);
      c++;
      start = mid && (c == 3);
      if (bw_tx) nbt++;
      if (bw_rx) nbr++;
      if (ttx < 0 && (dn_tx || er_tx)) begin ttx = c; etx = er_tx; end
      if (trx < 0 && (dn_rx || er_rx)) begin trx = c; erx = er_rx; end
    end
    start = 1'b0;
    xt = exp_time(1'b1, xet, nbxt);
    xr = exp_time(1'b0, xer, nbxr);
    rq = xet ? (xt > 0 && lat[4] < PL && lat[3] < PL && lat[2] < PL && lat[0] < PL && lat[1] < PL ? "R6" : "R4")
             : (mid ? "R8" : "R3");
    chk(etx == xet, rq, etx, xet);
    chk(ttx == xt, rq, ttx, xt);
    chk(erx == xer, xer ? "R4" : "R7", erx, xer);
    chk(trx == xr, xer ? "R4" : "R7", trx, xr);
    chk(nbt == nbxt, "R5", nbt, nbxt);
    chk(nbr == nbxr, "R5", nbr, nbxr);
    if (xet) chk(ctl_tx == 16'd0, "R4", ctl_tx, 0);
    if (!xer) chk(ctl_rx == 16'h001f && dn_rx, "R7", ctl_rx, 16'h001f);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk(sc_tx && sc_rx, "R9", sc_tx + sc_rx, 2);
    chk(ctl_tx == 16'd0 && ctl_rx == 16'd0 && !dn_tx && !dn_rx, "R9", ctl_tx | ctl_rx, 0);
    chk(er_tx == xet && er_rx == xer, "R10", er_tx, xet);
    @(negedge clk);
    chk(!sc_tx && !sc_rx, "R9", sc_tx + sc_rx, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    setlat(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(ctl_tx == 16'd0 && ctl_rx == 16'd0, "R1", ctl_tx | ctl_rx, 0);
    chk(!dn_tx && !er_tx && !bw_tx && !sc_tx && !dn_rx && !er_rx && !bw_rx && !sc_rx, "R1", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_tx == 16'd0 && !dn_tx && !er_tx, "R1", ctl_tx, 0);
    run(1'b0);                          // R3 fastest path
    setlat(3, 2, 5, 1, 4, 30); run(1'b0);
    setlat(PL - 1, PL - 1, PL - 1, PL - 1, PL - 1, 0); run(1'b0); // R4 last permitted sample
    setlat(0, PL, 0, 0, 0, 0); run(1'b0);                          // R4 first step stuck
    setlat(2, 1, 0, 3, PL, 0); run(1'b0);                          // R4 frame sync stuck
    setlat(0, 0, 0, 0, 0, RL); run(1'b0);                          // R6 last ready sample
    setlat(0, 0, 0, 0, 0, RL + 1); run(1'b0);                      // R6 ready timeout
    setlat(1, 1, 1, 1, 1, 2); run(1'b0);                           // R10 start after error
    setlat(4, 3, 2, 1, 6, 12); run(1'b1);                          // R8 start mid-sequence
    for (int k = 0; k < 24; k++) begin
      setlat($urandom_range(0, PL + 2), $urandom_range(0, PL + 2), $urandom_range(0, PL + 2),
             $urandom_range(0, PL + 2), $urandom_range(0, PL + 2), $urandom_range(0, 70));
      run(k % 5 == 0);
    end
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end             // R9 stop wins
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    chk(ctl_tx == 16'd0 && ctl_rx == 16'd0, "R9", ctl_tx | ctl_rx, 0);
    chk(viol == 0, "R2", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule